// File: doc/BRIEF.md
# Stochastic Binary Neuron Accumulator

This block evaluates one unit of a layered network whose units exchange single bits. A start pulse captures a 32-bit vector of binary unit states from the previous layer and clears a 16-bit signed accumulator. Over the next 32 clocks the block takes in one signed weight per clock. The input vector rotates left one place per weight, and its top bit selects the operation: a 1 adds the weight and a 0 subtracts it. No multiplier is needed. The sum saturates at the 16-bit signed limits.

After the last weight the accumulator holds the net input X. On the next clock the block decides the unit's output bit. When the training flag is set, a random signed bias r from an internal 16-bit LFSR is added to X first. The resulting threshold behaves like a sigmoid on average. The output bit is 1 only when the (biased) sum is strictly positive. The bit is also shifted into a 32-bit output vector, which forms the input vector for the next layer. A one-cycle done pulse marks the result. Weight storage and the sequencing of whole layers are handled outside this block.

Top module: `stoch_neuron`

## Requirements
- R1: After reset, sum_out, y_bit, out_vec and done are all zero.
- R2: A start pulse accepted while idle loads in_vec and clears the accumulator, so sum_out reads 0 on the cycle after start.
- R3: On each of the 32 clocks after start, the block applies one weight. The k-th weight (k = 0..31) is added when in_vec bit 31-k is 1 and subtracted when it is 0. The most significant bit is used first.
- R4: Every add or subtract saturates at +32767 or -32768 instead of wrapping, and accumulation continues from the clamped value.
- R5: done goes high for exactly one cycle, one clock after the 32nd weight has been applied. sum_out then holds X.
- R6: With train low at the decision clock, y_bit is 1 when X > 0 and 0 when X <= 0.
- R7: With train high, a bias r is added to X before the decision. r is the low RANGE_BITS bits of the LFSR taken as a signed value, which is within [-128, 127] by default. The LFSR advances once per decision. A unit with X = 0 therefore produces both output values over repeated decisions, and |X| > 128 gives the sign of X.
- R8: At each decision, out_vec shifts left by one and the new y_bit enters at bit 0.
- R9: A start pulse that arrives while an evaluation is in progress is ignored.
- R10: Outside an evaluation, sum_out holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation; captures in_vec |
| in_vec | input | 32 | Binary states of the previous layer |
| weight | input | 16 | Signed weight, one per clock after start |
| train | input | 1 | Adds the random bias at the decision |
| sum_out | output | 16 | Signed accumulator value (X after the last weight) |
| y_bit | output | 1 | Latest unit output bit |
| out_vec | output | 32 | Shift register of unit output bits |
| done | output | 1 | One-cycle pulse when y_bit is valid |

## Verification
The assertions check the following on every cycle: done lasts a single cycle and follows a decision; an accepted start clears the sum; the sum stays fixed while idle; saturation holds at both limits; the output vector shifts; and the unbiased decision matches the sign of the held sum. The bench's scenarios cover the rest. They show that weights pair with the input bits in most-significant-first order, that recovery after saturation is correct, that a mid-run start is ignored, and that the random bias flips a zero-sum unit while leaving a large-magnitude unit unchanged.

// File: rtl/stoch_neuron.sv
`timescale 1ns/1ps
module stoch_neuron #(
  parameter int N  = 32,
  parameter int W  = 16,
  parameter int RANGE_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [N-1:0]        in_vec,
  input  logic signed [W-1:0] weight,
  input  logic                train,
  output logic signed [W-1:0] sum_out,
  output logic                y_bit,
  output logic [N-1:0]        out_vec,
  output logic                done
);
  localparam int CW = $clog2(N);
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DEC} st_t;
  st_t state;

  logic [N-1:0]  in_reg;
  logic [CW-1:0] cnt;
  logic [15:0]   lfsr;

  logic acc_phase, dec_phase, cur_bit;
  assign acc_phase = (state == S_ACC);
  assign dec_phase = (state == S_DEC);
  assign cur_bit   = in_reg[N-1];

  logic signed [W:0] acc_x, w_x, step;
  logic signed [W-1:0] step_sat;
  assign acc_x = {sum_out[W-1], sum_out};
  assign w_x   = {weight[W-1], weight};
  assign step  = cur_bit ? acc_x + w_x : acc_x - w_x;
  assign step_sat = (step[W] != step[W-1]) ? (step[W] ? SMIN : SMAX) : step[W-1:0];

  logic signed [W-1:0] rnd;
  logic signed [W:0]   biased;
  logic                y_next;
  assign rnd    = {{(W-RANGE_BITS){lfsr[RANGE_BITS-1]}}, lfsr[RANGE_BITS-1:0]};
  assign biased = acc_x + (train ? {rnd[W-1], rnd} : '0);
  assign y_next = !biased[W] && (|biased);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      in_reg  <= '0;
      cnt     <= '0;
      sum_out <= '0;
      y_bit   <= 1'b0;
      out_vec <= '0;
      done    <= 1'b0;
      lfsr    <= 16'hACE1;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          in_reg  <= in_vec;
          sum_out <= '0;
          cnt     <= '0;
          state   <= S_ACC;
        end
        S_ACC: begin
          sum_out <= step_sat;
          in_reg  <= {in_reg[N-2:0], in_reg[N-1]};
          cnt     <= cnt + 1'b1;
          if (cnt == CW'(N-1)) state <= S_DEC;
        end
        S_DEC: begin
          y_bit   <= y_next;
          out_vec <= {out_vec[N-2:0], y_next};
          done    <= 1'b1;
          lfsr    <= lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stoch_neuron_chk.sv
`timescale 1ns/1ps
module stoch_neuron_chk #(
  parameter int N = 32,
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                train,
  input logic signed [W-1:0] weight,
  input logic signed [W-1:0] sum_out,
  input logic                y_bit,
  input logic [N-1:0]        out_vec,
  input logic                done,
  input logic                acc_phase,
  input logic                dec_phase,
  input logic                cur_bit
);
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  logic idle;
  assign idle = !acc_phase && !dec_phase;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (sum_out == '0 && !done && out_vec == '0 && !y_bit)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (start && idle) |=> (sum_out == '0 && acc_phase)); // R2
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (acc_phase && cur_bit && weight >= 0 && sum_out == SMAX) |=> sum_out == SMAX); // R4
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n) (acc_phase && !cur_bit && weight >= 0 && sum_out == SMIN) |=> sum_out == SMIN); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_AFTER_DEC: assert property (@(posedge clk) disable iff (!rst_n) dec_phase |=> done); // R5
  AST_PLAIN_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (dec_phase && !train) |=> (y_bit == (sum_out > 0))); // R6
  AST_VEC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) dec_phase |=> (out_vec[N-1:1] == $past(out_vec[N-2:0]) && out_vec[0] == y_bit)); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n) (acc_phase && start) |=> !idle); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!acc_phase && !(idle && start)) |=> $stable(sum_out)); // R10
endmodule

bind stoch_neuron stoch_neuron_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .train(train), .weight(weight),
  .sum_out(sum_out), .y_bit(y_bit), .out_vec(out_vec), .done(done),
  .acc_phase(acc_phase), .dec_phase(dec_phase), .cur_bit(cur_bit)
);

// File: tb/test_stoch_neuron.sv
`timescale 1ns/1ps
module test_stoch_neuron;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, train = 1'b0;
  logic [31:0] in_vec = '0;
  logic signed [15:0] weight = '0;
  logic signed [15:0] sum_out;
  logic y_bit, done;
  logic [31:0] out_vec;

  int checks = 0, failures = 0;
  logic [31:0] exp_vec = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  stoch_neuron i_stoch_neuron (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec), .weight(weight),
    .train(train), .sum_out(sum_out), .y_bit(y_bit), .out_vec(out_vec), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0]        v;
    logic signed [15:0] w;
    logic signed [15:0] x;
    logic               y;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'hFFFFFFFF,  16'sd10,  16'sd320, 1'b1},
    '{32'h00000000,  16'sd10, -16'sd320, 1'b0},
    '{32'hFFFF0000,  16'sd7,   16'sd0,   1'b0},
    '{32'h80000001,  16'sd5,  -16'sd140, 1'b0},
    '{32'hFFFF8000,  16'sd3,   16'sd6,   1'b1},
    '{32'hAAAAAAAA, -16'sd5,   16'sd0,   1'b0},
    '{32'h7FFFFFFF,  16'sd1,   16'sd30,  1'b1},
    '{32'h00000001, -16'sd1,   16'sd30,  1'b1}
  };

  // one evaluation; returns sum and y; checks R2, R5, R8, R10 along the way
  task automatic run(input logic [31:0] v, input logic signed [15:0] w, input bit ramp,
                     input bit tr, input bit poke,
                     output logic signed [15:0] xs, output logic yo);
    @(negedge clk); start = 1'b1; in_vec = v; train = tr;
    @(negedge clk); start = 1'b0;
    chk(sum_out == 0, "R2", sum_out, 0);
    for (int k = 0; k < 32; k++) begin
      weight = ramp ? 16'(k) : w;
      if (poke && k == 10) begin start = 1'b1; in_vec = ~v; end
      @(negedge clk); start = 1'b0;
    end
    chk(done == 1'b0, "R5", done, 0);
    xs = sum_out;
    @(negedge clk);
    chk(done == 1'b1, "R5", done, 1);
    chk(sum_out == xs, "R5", sum_out, xs);
    yo = y_bit;
    exp_vec = {exp_vec[30:0], yo};
    chk(out_vec == exp_vec, "R8", out_vec, exp_vec);
    @(negedge clk);
    chk(done == 1'b0, "R5", done, 0);
    chk(sum_out == xs, "R10", sum_out, xs);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic signed [15:0] xs;
    logic yo;
    int ones;
    repeat (3) @(negedge clk);
    chk(sum_out == 0 && y_bit == 0 && out_vec == 0 && done == 0, "R1", {sum_out, y_bit, out_vec, done}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      run(TBL[i].v, TBL[i].w, 0, 0, 0, xs, yo);
      chk(xs == TBL[i].x, "R3", xs, TBL[i].x);
      chk(yo == TBL[i].y, "R6", yo, TBL[i].y);
    end

    run(32'h80000000, 0, 1, 0, 0, xs, yo);
    chk(xs == -16'sd496, "R3 order msb", xs, -496);
    run(32'h00000001, 0, 1, 0, 0, xs, yo);
    chk(xs == -16'sd434, "R3 order lsb", xs, -434);

    run(32'hFFFFFFFF, 16'sd32767, 0, 0, 0, xs, yo);
    chk(xs == 16'sd32767, "R4 high", xs, 32767);
    chk(yo == 1'b1, "R6", yo, 1);
    run(32'h00000000, 16'h8000, 0, 0, 0, xs, yo);
    chk(xs == 16'sd32767, "R4 sub min", xs, 32767);
    run(32'h00000000, 16'sd32767, 0, 0, 0, xs, yo);
    chk(xs == 16'h8000, "R4 low", xs, -32768);
    chk(yo == 1'b0, "R6", yo, 0);
    run(32'hFFFFFFFE, 16'sd2000, 0, 0, 0, xs, yo);
    chk(xs == 16'sd30767, "R4 recover", xs, 30767);

    run(32'hFFFFFFFF, 16'sd10, 0, 0, 1, xs, yo);
    chk(xs == 16'sd320, "R9", xs, 320);

    run(32'hFFFFFFFF, 16'sd10, 0, 1, 0, xs, yo);
    chk(yo == 1'b1, "R7 large pos", yo, 1);
    run(32'h00000000, 16'sd10, 0, 1, 0, xs, yo);
    chk(yo == 1'b0, "R7 large neg", yo, 0);

    ones = 0;
    for (int t = 0; t < 24; t++) begin
      run(32'hFFFF0000, 16'sd7, 0, 1, 0, xs, yo);
      ones += int'(yo);
    end
    chk(ones > 0 && ones < 24, "R7 zero sum both values", ones, 12);

    repeat (4) @(negedge clk);
    chk(sum_out == xs, "R10 idle", sum_out, xs);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule